// File: doc/BRIEF.md
# Post-Configuration Start-Up Release Sequencer

This block takes a programmable device from "configuration image loaded" to "running in user mode". Once the configuration logic reports a complete image, the sequencer counts edges of a chosen start-up clock. At fixed offsets from the edge where the done indication rises, it performs three steps. It stops holding the open-drain done pad low. It lets the user I/O leave tri-state. It deasserts the global set/reset. After three further start-up clock edges it raises a configuration-complete status, and only then are readback requests granted.

The start-up clock is either the configuration clock or a user clock, picked by a configuration option. Both arrive as single-cycle edge strobes in the block's own fabric clock domain. When the user clock is picked, the completion flag passes through a handoff stage clocked by the user strobe. That stage absorbs the unknown phase between the two clocks and delays the whole sequence by one start-up edge. The I/O release and the set/reset release each have their own 2-bit delay option. If start-up edges stop arriving, every output holds its current state.

Top module: `startup_release_seq`

## Requirements
- R1: A synchronous active-high reset forces done_pulldown=1, io_enable=0, gsr_active=1, cfg_complete=0 and readback_grant=0, and clears the handoff stage.
- R2: With sel_usr=0 the start-up edge is cfg_tick. The first such edge with cfg_loaded=1 clears done_pulldown at that clock edge.
- R3: With sel_usr=1 the start-up edge is usr_tick and cfg_tick has no effect. cfg_loaded is captured by one handoff register on each usr_tick, so done_pulldown clears on the second usr_tick that follows cfg_loaded rising.
- R4: io_enable rises on the start-up edge that comes io_dly edges after the done edge. io_dly is a 2-bit value from 0 to 3, and 0 means the done edge itself. The usual setting is 1.
- R5: gsr_active falls on the start-up edge that comes gsr_dly edges after the done edge. gsr_dly is a 2-bit value from 0 to 3, and the usual setting is 2.
- R6: cfg_complete rises on the third start-up edge after the done edge.
- R7: readback_grant is registered: it is 1 in a cycle only if readback_req was 1 and cfg_complete was already 1 in the cycle before. A request that is present while cfg_complete is 0 is refused.
- R8: In a cycle with no start-up edge, done_pulldown, io_enable, gsr_active and cfg_complete keep their values.
- R9: done_level, which models the pad, is 1 only when done_pulldown=0 and pullup_en=1.
- R10: Once released, each output stays released until reset, even if cfg_loaded falls or a delay option changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; start-up edges arrive as strobes on it |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tick | input | 1 | One-cycle strobe per configuration clock edge |
| usr_tick | input | 1 | One-cycle strobe per user clock edge |
| sel_usr | input | 1 | 1 = user clock drives start-up, 0 = configuration clock |
| cfg_loaded | input | 1 | Memory full and length count matched |
| io_dly | input | 2 | Edges from done to I/O release, 0 to 3 |
| gsr_dly | input | 2 | Edges from done to set/reset release, 0 to 3 |
| pullup_en | input | 1 | Pull-up on the done pad enabled |
| readback_req | input | 1 | Readback request |
| done_pulldown | output | 1 | 1 = done pad actively held low |
| done_level | output | 1 | Modelled logic level seen on the done pad |
| io_enable | output | 1 | 1 = user I/O leave tri-state |
| gsr_active | output | 1 | 1 = global set/reset still applied |
| cfg_complete | output | 1 | Configuration fully complete; readback unlocked |
| readback_grant | output | 1 | Registered grant for a readback request |

## Verification
Two kinds of event can land on the same start-up edge. The I/O release and the set/reset release coincide when io_dly equals gsr_dly. With both delays at zero they also coincide with done itself. The bench drives these equal settings on directed runs and judges each output against its own delay-driven expectation in that cycle. The second collision is a readback request held high in the very cycle cfg_complete rises. That request must be refused, and the grant may only appear one cycle later.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  localparam int unsigned EVT_IO  = 0;
  localparam int unsigned EVT_GSR = 1;
  localparam int unsigned EVT_CPL = 2;
  localparam int unsigned EVT_N   = 3;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/su_tick_src.sv
module su_tick_src #(
  parameter int unsigned HANDOFF_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_tick,
  input  logic usr_tick,
  input  logic sel_usr,
  input  logic cfg_loaded,
  output logic step,
  output logic ready
);
  logic [HANDOFF_STAGES-1:0] hand_q;

  genvar gi;
  generate
    for (gi = 0; gi < HANDOFF_STAGES; gi++) begin : g_hand
      always_ff @(posedge clk) begin
        if (rst) begin
          hand_q[gi] <= 1'b0;
        end else if (usr_tick) begin
          if (gi == 0) hand_q[gi] <= cfg_loaded;
          else         hand_q[gi] <= hand_q[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  always_comb begin
    if (sel_usr) begin
      step  = usr_tick;
      ready = hand_q[HANDOFF_STAGES-1];
    end else begin
      step  = cfg_tick;
      ready = cfg_loaded;
    end
  end
endmodule

// File: rtl/su_age_counter.sv
module su_age_counter #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SAT   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ready,
  output logic             done_q,
  output logic             done_nxt,
  output logic [CNT_W-1:0] age_nxt
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  logic [CNT_W-1:0] age_q;

  always_comb begin
    done_nxt = done_q | ready;
    if (!done_q)             age_nxt = '0;
    else if (age_q == SAT_V) age_nxt = age_q;
    else                     age_nxt = age_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      age_q  <= '0;
    end else if (step) begin
      done_q <= done_nxt;
      age_q  <= age_nxt;
    end
  end
endmodule

// File: rtl/su_release_gate.sv
module su_release_gate #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             done_nxt,
  input  logic [CNT_W-1:0] age_nxt,
  input  logic [CNT_W-1:0] thresh,
  output logic             released
);
  logic hit;
  assign hit = done_nxt && (age_nxt >= thresh);

  always_ff @(posedge clk) begin
    if (rst)       released <= 1'b0;
    else if (step) released <= released | hit;
  end
endmodule

// File: rtl/startup_release_seq.sv
module startup_release_seq
  import startup_seq_pkg::*;
#(
  parameter int unsigned DLY_W            = 2,
  parameter int unsigned DONE_TO_COMPLETE = 3,
  parameter int unsigned HANDOFF_STAGES   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_tick,
  input  logic             usr_tick,
  input  logic             sel_usr,
  input  logic             cfg_loaded,
  input  logic [DLY_W-1:0] io_dly,
  input  logic [DLY_W-1:0] gsr_dly,
  input  logic             pullup_en,
  input  logic             readback_req,
  output logic             done_pulldown,
  output logic             done_level,
  output logic             io_enable,
  output logic             gsr_active,
  output logic             cfg_complete,
  output logic             readback_grant
);
  localparam int unsigned CPL_W = $clog2(DONE_TO_COMPLETE + 1);
  localparam int unsigned CNT_W = max_u(DLY_W, CPL_W) + 1;
  localparam int unsigned SAT   = max_u(DONE_TO_COMPLETE, (1 << DLY_W) - 1);
  localparam int unsigned PAD_W = CNT_W - DLY_W;

  logic             step, ready;
  logic             done_q, done_nxt;
  logic [CNT_W-1:0] age_nxt;
  logic [CNT_W-1:0] thresh [EVT_N];
  logic [EVT_N-1:0] rel;
  logic             grant_q;

  su_tick_src #(.HANDOFF_STAGES(HANDOFF_STAGES)) u_src (
    .clk(clk), .rst(rst), .cfg_tick(cfg_tick), .usr_tick(usr_tick),
    .sel_usr(sel_usr), .cfg_loaded(cfg_loaded), .step(step), .ready(ready)
  );

  su_age_counter #(.CNT_W(CNT_W), .SAT(SAT)) u_age (
    .clk(clk), .rst(rst), .step(step), .ready(ready),
    .done_q(done_q), .done_nxt(done_nxt), .age_nxt(age_nxt)
  );

  assign thresh[EVT_IO]  = {{PAD_W{1'b0}}, io_dly};
  assign thresh[EVT_GSR] = {{PAD_W{1'b0}}, gsr_dly};
  assign thresh[EVT_CPL] = CNT_W'(DONE_TO_COMPLETE);

  genvar ge;
  generate
    for (ge = 0; ge < EVT_N; ge++) begin : g_evt
      su_release_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst(rst), .step(step), .done_nxt(done_nxt),
        .age_nxt(age_nxt), .thresh(thresh[ge]), .released(rel[ge])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= readback_req & rel[EVT_CPL];
  end

  assign done_pulldown  = ~done_q;
  assign done_level     = done_q & pullup_en;
  assign io_enable      = rel[EVT_IO];
  assign gsr_active     = ~rel[EVT_GSR];
  assign cfg_complete   = rel[EVT_CPL];
  assign readback_grant = grant_q;
endmodule

// File: rtl/startup_release_seq_chk.sv
module startup_release_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_tick,
  input logic       usr_tick,
  input logic       sel_usr,
  input logic       readback_req,
  input logic       pullup_en,
  input logic       done_pulldown,
  input logic       done_level,
  input logic       io_enable,
  input logic       gsr_active,
  input logic       cfg_complete,
  input logic       readback_grant
);
  logic rst_d = 1'b0;
  logic any_step;
  assign any_step = sel_usr ? usr_tick : cfg_tick;

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d)
      AST_RESET_OUTS: assert (done_pulldown && !io_enable && gsr_active && !cfg_complete); // R1
  end

  AST_FREEZE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !any_step |=> $stable({done_pulldown, io_enable, gsr_active, cfg_complete})); // R8

  AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    io_enable |-> !done_pulldown); // R4

  AST_GSR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    !gsr_active |-> !done_pulldown); // R5

  AST_COMPLETE_ALL_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cfg_complete |-> (io_enable && !gsr_active)); // R6

  AST_GRANT_AFTER_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    readback_grant |-> ($past(cfg_complete) && $past(readback_req))); // R7

  AST_LEVEL_NEEDS_PULLUP: assert property (@(posedge clk) disable iff (rst)
    done_level |-> (pullup_en && !done_pulldown)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !done_pulldown |=> !done_pulldown); // R10
endmodule

bind startup_release_seq startup_release_seq_chk chk_i (
  .clk(clk), .rst(rst), .cfg_tick(cfg_tick), .usr_tick(usr_tick),
  .sel_usr(sel_usr), .readback_req(readback_req), .pullup_en(pullup_en),
  .done_pulldown(done_pulldown), .done_level(done_level),
  .io_enable(io_enable), .gsr_active(gsr_active),
  .cfg_complete(cfg_complete), .readback_grant(readback_grant)
);

// File: tb/startup_release_seq_tb_top.sv
module startup_release_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tick = 0, usr_tick = 0, sel_usr = 0, cfg_loaded = 0;
  logic [1:0] io_dly = 2'd1, gsr_dly = 2'd2;
  logic pullup_en = 1, readback_req = 0;
  logic done_pulldown, done_level, io_enable, gsr_active, cfg_complete, readback_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench reference state
  bit m_sync, m_done, m_io, m_grel, m_cpl, m_grant;
  int m_k;

  always #2 clk = ~clk;

  startup_release_seq dut_i (
    .clk(clk), .rst(rst), .cfg_tick(cfg_tick), .usr_tick(usr_tick),
    .sel_usr(sel_usr), .cfg_loaded(cfg_loaded), .io_dly(io_dly),
    .gsr_dly(gsr_dly), .pullup_en(pullup_en), .readback_req(readback_req),
    .done_pulldown(done_pulldown), .done_level(done_level),
    .io_enable(io_enable), .gsr_active(gsr_active),
    .cfg_complete(cfg_complete), .readback_grant(readback_grant)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic int sat3(input int v);
    return (v > 3) ? 3 : v;
  endfunction

  task automatic model_clear();
    m_sync = 0; m_done = 0; m_io = 0; m_grel = 0; m_cpl = 0; m_grant = 0; m_k = 0;
  endtask

  task automatic check_all();
    chk(sel_usr ? "R3 done" : "R2 done", done_pulldown, !m_done);
    chk("R4 io_enable", io_enable, m_io);
    chk("R5 gsr_active", gsr_active, !m_grel);
    chk("R6 cfg_complete", cfg_complete, m_cpl);
    chk("R7 readback_grant", readback_grant, m_grant);
    chk("R9 done_level", done_level, m_done & pullup_en);
  endtask

  // one fabric cycle: drive away from edge, update reference at edge, sample after
  task automatic cyc(input logic c, input logic u, input logic req);
    bit old_sync, stp, prev_cpl;
    @(negedge clk);
    cfg_tick = c; usr_tick = u; readback_req = req;
    @(posedge clk);
    old_sync = m_sync;
    prev_cpl = m_cpl;
    stp = sel_usr ? u : c;
    if (stp) begin
      if (m_done) m_k = sat3(m_k + 1);
      else if (sel_usr ? old_sync : cfg_loaded) begin m_done = 1; m_k = 0; end
      if (m_done) begin
        if (m_k >= int'(io_dly))  m_io = 1;
        if (m_k >= int'(gsr_dly)) m_grel = 1;
        if (m_k >= 3)             m_cpl = 1;
      end
    end
    if (u) m_sync = cfg_loaded;
    m_grant = req & prev_cpl;
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cfg_tick = 0; usr_tick = 0; readback_req = 0;
    repeat (2) @(posedge clk);
    model_clear();
    #1;
    chk("R1 done_pulldown", done_pulldown, 1'b1);
    chk("R1 io_enable", io_enable, 1'b0);
    chk("R1 gsr_active", gsr_active, 1'b1);
    chk("R1 cfg_complete", cfg_complete, 1'b0);
    chk("R1 readback_grant", readback_grant, 1'b0);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    model_clear();

    // directed: cfg clock, equal delays -> io and gsr release on same edge
    sel_usr = 0; io_dly = 2; gsr_dly = 2; cfg_loaded = 0;
    do_reset();
    cyc(1, 0, 1);                 // R2: edge without loaded does nothing
    cfg_loaded = 1;
    for (int i = 0; i < 6; i++) cyc(1, 0, 1);  // R4 R5 R6 R7 collide cases

    // directed: zero delays, all released on done edge
    io_dly = 0; gsr_dly = 0;
    do_reset();
    cyc(1, 0, 0);
    chk("R4 io on done edge", io_enable, 1'b1);
    chk("R5 gsr on done edge", gsr_active, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);

    // directed: user clock, cfg ticks ignored, handoff adds one edge
    sel_usr = 1; io_dly = 1; gsr_dly = 2;
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    chk("R3 cfg_tick ignored", done_pulldown, 1'b1);
    cyc(0, 1, 0);
    chk("R3 first usr edge holds done low", done_pulldown, 1'b1);
    cyc(0, 1, 0);
    chk("R3 second usr edge releases done", done_pulldown, 1'b0);

    // directed freeze: no selected edges for a while
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 0);
      chk("R8 frozen io", io_enable, 1'b0);
      chk("R8 frozen gsr", gsr_active, 1'b1);
    end
    for (int i = 0; i < 4; i++) cyc(0, 1, 1);

    // directed sticky: drop loaded and change delays after release
    cfg_loaded = 0; io_dly = 3; gsr_dly = 3;
    for (int i = 0; i < 3; i++) cyc(0, 1, 0);
    chk("R10 io stays", io_enable, 1'b1);
    chk("R10 gsr stays released", gsr_active, 1'b0);
    chk("R10 done stays", done_pulldown, 1'b0);

    // pull-up disabled: pad not high
    pullup_en = 0;
    cyc(0, 0, 0);
    chk("R9 no pullup level low", done_level, 1'b0);
    pullup_en = 1;

    // constrained random runs
    for (int s = 0; s < 60; s++) begin
      sel_usr = 1'($urandom_range(0, 1));
      io_dly  = 2'($urandom_range(0, 3));
      gsr_dly = 2'($urandom_range(0, 3));
      cfg_loaded = 0;
      do_reset();
      for (int i = 0; i < 50; i++) begin
        if (i == 3 + (s % 5)) cfg_loaded = 1;
        if ($urandom_range(0, 19) == 0) cfg_loaded = ~cfg_loaded;
        if ($urandom_range(0, 15) == 0) io_dly = 2'($urandom_range(0, 3));
        pullup_en = ($urandom_range(0, 7) != 0);
        cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
            ($urandom_range(0, 1) == 1));
      end
    end

    finish_run();
  end
endmodule